// File: doc/BRIEF.md
# I2C Master Event Status and Interrupt Unit

This unit gathers the master-side events of an I2C controller into a bank of status flags, pairs every flag with its own interrupt enable, and drives one registered interrupt request. The bit-level bus engine sits outside the block. It reports each event as a single-cycle pulse on a seven-bit event input. The unit also holds the master control byte that the engine consumes: start request, forced stop, interface enable, pin override, line override values and the non-FIFO mode switch.

Software reaches the unit through a small 32-bit register port with a two-bit word address. Status flags are cleared by writing zero to their positions. A handler can therefore read the status, write back the inverted value, and clear only the flags it has seen. A flag that arrives between the read and the write survives.

Arbitration loss wipes the control byte. A NACK opens a guard window of programmable length. During that window, writes to the control, status and enable registers are dropped, and a sticky error bit records each attempt.

Top module: `i2cm_stat_irq`

## Requirements
- R1: While `rst` is high at a clock edge, every flag, enable, control bit, guard length, guard count and the error bit reset to zero, and `irq_o` and `reg_rdata_o` read zero after that edge.
- R2: A pulse on `evt_i[k]` sets status flag k at the next clock edge. The flag positions are: bit 0 address phase done, bit 1 data received, bit 2 data transmitted, bit 3 transmit data empty, bit 4 stop sent, bit 5 arbitration lost, bit 6 NACK received. Status is read at word address 1, bits 6:0.
- R3: A write to word address 1 clears every flag whose `reg_wdata_i` bit is 0 and leaves every flag whose bit is 1 unchanged. When no event and no such write occur, the flags hold.
- R4: An event pulse in the same cycle as a write that clears that flag wins: the flag is set after the edge.
- R5: The enable register sits at word address 2, bits 6:0, with the same positions as the status flags. `irq_o` is a register loaded each cycle with the OR over all bits of (flags AND enables). It therefore follows the flag and enable registers one cycle later, and stays high until every enabled set flag is cleared or disabled.
- R6: The control register sits at word address 0: bit 0 start generation, bit 1 force stop, bit 3 interface enable, bit 4 pin override, bit 5 SDA override value, bit 6 SCL override value, bit 7 non-FIFO mode. Bit 2 always holds 0. `ctl_o` shows the stored byte. A read returns the stored byte except bit 5, which returns the live `sda_sense_i` level so that software can use it as a bus-busy check.
- R7: A pulse on `evt_i[5]` (arbitration lost) zeroes the control register at the next edge, overriding a control write in the same cycle.
- R8: A pulse on `evt_i[6]` (NACK) loads the guard count with the guard length. During the following guard-length cycles, writes to word addresses 0, 1 and 2 have no effect. A NACK inside the window restarts it, and a guard length of 0 opens no window.
- R9: Each dropped write sets a sticky error bit, read at word address 3, bit 16. Any write to word address 3 clears that bit and loads the guard length from `reg_wdata_i[7:0]`, which reads back at bits 7:0.
- R10: `reg_rdata_o` is registered. After each edge it holds the register selected by `reg_addr_i` at that edge, with the contents that register had before the edge.
- R11: A NACK pulse and a stop-sent pulse in the same cycle set both flags, and one status read shows both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Single-cycle event pulses from the bus engine, status bit layout |
| sda_sense_i | input | 1 | Sampled SDA line level, read back in control bit 5 |
| reg_addr_i | input | 2 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| ctl_o | output | 8 | Stored control byte to the bus engine |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench aims at the collisions:
- An event landing on the cycle of a write-back clear. A design that let the write win would lose a flag, and the handler would never see it.
- An arbitration loss meeting a control write. A design that let the write win would leave start generation armed after the master dropped off the bus.
- The NACK guard window, probed at its last blocked cycle and its first open cycle. An off-by-one count lets an early write through or drops a legal one.
- The write that clears the sticky error bit. A design that never cleared it would report a fault for good.
- The live SDA bit in control reads. A stale value would hide a busy bus.

Random event and register traffic then runs against a cycle model, which catches a missed one-cycle latency on the interrupt or on read data.

// File: rtl/i2cm_stat_pkg.sv
package i2cm_stat_pkg;
  localparam int FLAG_N  = 7;
  localparam int CTL_W   = 8;
  localparam int DATA_W  = 32;
  localparam int ERR_BIT = 16;

  localparam int FLG_ADDR = 0;
  localparam int FLG_RXD  = 1;
  localparam int FLG_TXD  = 2;
  localparam int FLG_TXE  = 3;
  localparam int FLG_STOP = 4;
  localparam int FLG_ARB  = 5;
  localparam int FLG_NACK = 6;

  localparam int CTL_START = 0;
  localparam int CTL_FSTOP = 1;
  localparam int CTL_RSV   = 2;
  localparam int CTL_IFEN  = 3;
  localparam int CTL_OVR   = 4;
  localparam int CTL_SDA   = 5;
  localparam int CTL_SCL   = 6;
  localparam int CTL_NOFF  = 7;

  typedef enum logic [1:0] {
    RA_CTL   = 2'd0,
    RA_STAT  = 2'd1,
    RA_IEN   = 2'd2,
    RA_GUARD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/i2cm_flag_bank.sv
module i2cm_flag_bank #(
  parameter int FLAG_N = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_N-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic [FLAG_N-1:0] clr_keep_i,
  input  logic              en_we_i,
  input  logic [FLAG_N-1:0] en_data_i,
  output logic [FLAG_N-1:0] flags_o,
  output logic [FLAG_N-1:0] en_o,
  output logic              irq_o
);
  logic [FLAG_N-1:0] flag_q, flag_nxt, en_q;
  logic              irq_q;

  for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
    // the event term is ORed last, so a pulse beats a clearing write
    assign flag_nxt[k] = evt_i[k] | (flag_q[k] & ~(clr_we_i & ~clr_keep_i[k]));

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
      evt_i[k] |=> flag_q[k]); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      if (en_we_i) en_q <= en_data_i;
      irq_q <= |(flag_q & en_q);
    end
  end

  assign flags_o = flag_q;
  assign en_o    = en_q;
  assign irq_o   = irq_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (evt_i == '0 && !clr_we_i) |=> $stable(flag_q)); // R3
  AST_IRQ_FALLS_WHEN_CLEAN: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & en_q) == '0) |=> !irq_q); // R5
endmodule

// File: rtl/i2cm_nack_guard.sv
module i2cm_nack_guard #(
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nack_i,
  input  logic               prot_wr_i,
  input  logic               len_we_i,
  input  logic [GUARD_W-1:0] len_data_i,
  output logic               block_o,
  output logic               active_o,
  output logic [GUARD_W-1:0] len_o,
  output logic               err_o
);
  logic [GUARD_W-1:0] len_q, cnt_q;
  logic               err_q;

  assign active_o = (cnt_q != '0);
  assign block_o  = prot_wr_i & active_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (len_we_i) len_q <= len_data_i;
      if (nack_i)        cnt_q <= len_q;
      else if (active_o) cnt_q <= cnt_q - 1'b1;
      if (block_o)       err_q <= 1'b1;
      else if (len_we_i) err_q <= 1'b0;
    end
  end

  assign len_o = len_q;
  assign err_o = err_q;

  AST_BLOCK_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
    block_o |=> err_q); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !len_we_i) |=> err_q); // R9
  AST_NACK_OPENS: assert property (@(posedge clk) disable iff (rst)
    (nack_i && len_q != '0) |=> active_o); // R8
endmodule

// File: rtl/i2cm_ctl_reg.sv
module i2cm_ctl_reg #(
  parameter int                CTL_W   = 8,
  parameter logic [CTL_W-1:0]  WR_MASK = 8'hFB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             arb_lost_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)             ctl_q <= '0;
    else if (arb_lost_i) ctl_q <= '0;
    else if (we_i)       ctl_q <= wdata_i & WR_MASK;
  end

  assign ctl_o = ctl_q;

  AST_ARB_ZEROES_CTL: assert property (@(posedge clk) disable iff (rst)
    arb_lost_i |=> (ctl_q == '0)); // R7
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctl_q & ~WR_MASK) == '0); // R6
endmodule

// File: rtl/i2cm_stat_irq.sv
module i2cm_stat_irq
  import i2cm_stat_pkg::*;
#(
  parameter int GUARD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_N-1:0] evt_i,
  input  logic              sda_sense_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              irq_o
);
  localparam logic [CTL_W-1:0] CTL_WMASK = ~(CTL_W'(1) << CTL_RSV);

  reg_addr_e          ra;
  logic               wr_ctl, wr_stat, wr_ien, wr_guard, prot_wr, blocked;
  logic               guard_active, guard_err;
  logic [GUARD_W-1:0] guard_len;
  logic [FLAG_N-1:0]  flags, ien;
  logic [DATA_W-1:0]  rd_nxt, rd_q;
  logic               unused_wdata;

  assign ra       = reg_addr_e'(reg_addr_i);
  assign prot_wr  = reg_wr_i & (ra != RA_GUARD);
  assign wr_ctl   = reg_wr_i & (ra == RA_CTL)  & ~blocked;
  assign wr_stat  = reg_wr_i & (ra == RA_STAT) & ~blocked;
  assign wr_ien   = reg_wr_i & (ra == RA_IEN)  & ~blocked;
  assign wr_guard = reg_wr_i & (ra == RA_GUARD);
  assign unused_wdata = ^reg_wdata_i;

  i2cm_flag_bank #(.FLAG_N(FLAG_N)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .clr_we_i   (wr_stat),
    .clr_keep_i (reg_wdata_i[FLAG_N-1:0]),
    .en_we_i    (wr_ien),
    .en_data_i  (reg_wdata_i[FLAG_N-1:0]),
    .flags_o    (flags),
    .en_o       (ien),
    .irq_o      (irq_o)
  );

  i2cm_nack_guard #(.GUARD_W(GUARD_W)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .nack_i     (evt_i[FLG_NACK]),
    .prot_wr_i  (prot_wr),
    .len_we_i   (wr_guard),
    .len_data_i (reg_wdata_i[GUARD_W-1:0]),
    .block_o    (blocked),
    .active_o   (guard_active),
    .len_o      (guard_len),
    .err_o      (guard_err)
  );

  i2cm_ctl_reg #(.CTL_W(CTL_W), .WR_MASK(CTL_WMASK)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .we_i       (wr_ctl),
    .wdata_i    (reg_wdata_i[CTL_W-1:0]),
    .arb_lost_i (evt_i[FLG_ARB]),
    .ctl_o      (ctl_o)
  );

  always_comb begin
    rd_nxt = '0;
    unique case (ra)
      RA_CTL: begin
        rd_nxt[CTL_W-1:0] = ctl_o;
        rd_nxt[CTL_SDA]   = sda_sense_i;
      end
      RA_STAT: rd_nxt[FLAG_N-1:0] = flags;
      RA_IEN:  rd_nxt[FLAG_N-1:0] = ien;
      RA_GUARD: begin
        rd_nxt[GUARD_W-1:0] = guard_len;
        rd_nxt[ERR_BIT]     = guard_err;
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign reg_rdata_o = rd_q;

  AST_GUARD_HOLDS_CTL: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && ra == RA_CTL && guard_active && !evt_i[FLG_ARB]) |=> $stable(ctl_o)); // R8
  AST_GUARD_HOLDS_IEN: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && ra == RA_IEN && guard_active) |=> $stable(ien)); // R8
  AST_GUARD_FITS: assert property (@(posedge clk) GUARD_W < ERR_BIT); // R9
endmodule

// File: tb/i2cm_stat_irq_tb_top.sv
module i2cm_stat_irq_tb_top;
  localparam int GW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [6:0]  evt = '0;
  logic        sda = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [7:0]  ctl;
  logic        irq;

  i2cm_stat_irq #(.GUARD_W(GW)) dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .sda_sense_i(sda),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .ctl_o(ctl), .irq_o(irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [6:0]    m_flags = '0, m_en = '0;
  logic [7:0]    m_ctl = '0;
  logic [GW-1:0] m_glen = '0, m_gcnt = '0;
  logic          m_err = 1'b0, m_irq = 1'b0;
  logic [31:0]   m_rd = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(logic [1:0] a);
    logic [31:0] r = '0;
    case (a)
      2'd0: begin r[7:0] = m_ctl; r[5] = sda; end
      2'd1: r[6:0] = m_flags;
      2'd2: r[6:0] = m_en;
      default: begin r[GW-1:0] = m_glen; r[16] = m_err; end
    endcase
    return r;
  endfunction

  task automatic step();
    logic blk = wr && (m_gcnt != 0) && (addr != 2'd3);
    logic [6:0] f_n = ((wr && addr == 2'd1 && !blk) ? (m_flags & wd[6:0]) : m_flags) | evt;
    logic [6:0] e_n = (wr && addr == 2'd2 && !blk) ? wd[6:0] : m_en;
    logic [7:0] c_n = evt[5] ? 8'h00 : ((wr && addr == 2'd0 && !blk) ? (wd[7:0] & 8'hFB) : m_ctl);
    logic [GW-1:0] g_n = evt[6] ? m_glen : ((m_gcnt != 0) ? m_gcnt - 1'b1 : '0);
    logic [GW-1:0] l_n = (wr && addr == 2'd3) ? wd[GW-1:0] : m_glen;
    logic er_n = blk ? 1'b1 : ((wr && addr == 2'd3) ? 1'b0 : m_err);
    logic i_n = |(m_flags & m_en);
    logic [31:0] r_n = rd_model(addr);
    if (rst) begin
      f_n = '0; e_n = '0; c_n = '0; g_n = '0; l_n = '0; er_n = 1'b0; i_n = 1'b0; r_n = '0;
    end
    @(posedge clk);
    @(negedge clk);
    m_flags = f_n; m_en = e_n; m_ctl = c_n; m_gcnt = g_n; m_glen = l_n;
    m_err = er_n; m_irq = i_n; m_rd = r_n;
    check("R5 irq", {31'b0, irq}, {31'b0, m_irq});
    check("R6 ctl_o", {24'b0, ctl}, {24'b0, m_ctl});
    check("R10 rdata", rd, m_rd);
  endtask

  task automatic idle();
    evt = '0; wr = 1'b0;
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    evt = '0; wr = 1'b1; addr = a; wd = d; step(); idle();
  endtask

  task automatic rreg(logic [1:0] a);
    idle(); addr = a; step();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7211));
    @(negedge clk);
    rst = 1'b1; step(); step();
    check("R1 rdata after reset", rd, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 ctl after reset", {24'b0, ctl}, 32'h0);
    rst = 1'b0;
    rreg(2'd3);
    check("R1 guard reg after reset", rd, 32'h0);

    wreg(2'd2, 32'h7F);
    evt = 7'h01; step(); idle();
    rreg(2'd1);
    check("R2 address-done flag", rd, 32'h01);
    check("R5 irq raised", {31'b0, irq}, 32'h1);

    evt = 7'h50; step(); idle();
    rreg(2'd1);
    check("R11 nack and stop together", rd, 32'h51);

    evt = 7'h02; wr = 1'b1; addr = 2'd1; wd = ~32'h51; step(); idle();
    rreg(2'd1);
    check("R4 event beats clear", rd, 32'h02);
    wreg(2'd1, ~32'h02);
    evt = 7'h0C; step(); idle();
    wreg(2'd1, 32'hFFFF_FFF7);
    rreg(2'd1);
    check("R3 partial write-zero clear", rd, 32'h04);
    wreg(2'd1, 32'h0);
    rreg(2'd1);
    check("R3 full clear", rd, 32'h0);
    step();
    check("R5 irq dropped", {31'b0, irq}, 32'h0);

    wreg(2'd0, 32'hFF);
    check("R6 reserved bit stays zero", {24'b0, ctl}, 32'hFB);
    sda = 1'b0; rreg(2'd0);
    check("R6 sda sense low", rd, 32'hDB);
    sda = 1'b1; rreg(2'd0);
    check("R6 sda sense high", rd, 32'hFB);

    evt = 7'h20; wr = 1'b1; addr = 2'd0; wd = 32'h09; step(); idle();
    check("R7 arbitration lost zeroes control", {24'b0, ctl}, 32'h0);

    wreg(2'd1, 32'h0);
    wreg(2'd3, 32'h3);
    evt = 7'h40; step(); idle();
    wreg(2'd0, 32'h01);
    check("R8 control write blocked", {24'b0, ctl}, 32'h0);
    wreg(2'd2, 32'h00);
    rreg(2'd2);
    check("R8 enable write blocked", rd, 32'h7F);
    wreg(2'd0, 32'h01);
    check("R8 write accepted after window", {24'b0, ctl}, 32'h01);
    rreg(2'd3);
    check("R9 sticky error set", rd, 32'h0001_0003);
    wreg(2'd3, 32'h0);
    rreg(2'd3);
    check("R9 error cleared by guard write", rd, 32'h0);
    evt = 7'h40; step(); idle();
    wreg(2'd0, 32'h08);
    check("R8 zero length opens no window", {24'b0, ctl}, 32'h08);

    for (int i = 0; i < 4000; i++) begin
      evt  = (($urandom % 6) == 0) ? 7'($urandom) : 7'h0;
      wr   = (($urandom % 3) == 0);
      addr = 2'($urandom);
      wd   = $urandom;
      if (addr == 2'd3) wd = wd & 32'h0000_0007;
      sda  = 1'($urandom);
      step();
    end
    idle();
    finish_run();
  end
endmodule